// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block runs a block memory operation on its own once started. It takes a source pointer, a destination pointer, a byte count, a comparison byte and the current flag byte. Then it walks memory through a simple synchronous port with one address, a read strobe, a write strobe and separate read and write data buses. Copy operations move bytes from the source pointer to the destination pointer. Search operations compare the comparison byte against the byte at the source pointer. Both kinds move their pointers up or down by one per step and count the byte counter down by one per step.

The three-bit operation code selects copy or search, single step or repeat, and increment or decrement. A single-step operation does exactly one step. A repeat copy ends only when the count reaches zero. A repeat search ends at the first byte equal to the comparison byte, or when the count reaches zero, whichever comes first. The updated pointers, count and flag byte appear on outputs. A one-cycle done pulse marks the end of the operation.

The memory returns read data in the cycle after the read strobe and holds it until the next read. Writes take effect at the clock edge that samples the write strobe.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are all 0.
- R2: A copy step takes three cycles. The first asserts mem_rd with mem_addr at the source pointer. The second asserts mem_wr with mem_addr at the destination pointer and mem_wdata equal to the byte read. The third is a bookkeeping cycle with no strobe.
- R3: Operation code bit 0 selects the direction: 0 adds one to each moving pointer per step and 1 subtracts one. A copy moves both pointers and a search moves only the source pointer.
- R4: Each step decrements the count by exactly one, modulo 2^16. A start count of 0000h therefore becomes FFFFh after the first step.
- R5: With operation code bit 1 = 1 and bit 2 = 0 (repeat copy), steps continue back to back until the count reaches zero. With bit 1 = 0, exactly one step runs.
- R6: A search step (bit 2 = 1) takes two cycles: a read of the source pointer, then a bookkeeping cycle with no strobe. It never writes memory and leaves the destination pointer unchanged.
- R7: A repeat search (bits 2 and 1 both 1) stops after the first step whose byte equals the comparison byte, or after the step that brings the count to zero.
- R8: The flag layout is S = bit 7, Z = bit 6, H = bit 4, P/V = bit 2, N = bit 1 and C = bit 0. After each copy step, H = 0, N = 0 and P/V = 1 exactly when the count is non-zero. S, Z, C and bits 5 and 3 keep their start values.
- R9: After each search step, with d = comparison byte minus memory byte (mod 256), S = d[7], Z = 1 when d = 0, H = 1 when the low nibble of the comparison byte is below that of the memory byte, N = 1, and P/V = 1 exactly when the count is non-zero. C and bits 5 and 3 keep their start values.
- R10: done is high for exactly one cycle, the cycle after the final bookkeeping cycle. In that cycle busy is 0 and the outputs hold the final pointers, count and flags.
- R11: start is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| mode | input | 3 | Bit 2 search, bit 1 repeat, bit 0 decrement |
| src_in | input | 16 | Start source pointer |
| dst_in | input | 16 | Start destination pointer |
| cnt_in | input | 16 | Start byte count |
| acc_in | input | 8 | Comparison byte for search |
| flags_in | input | 8 | Start flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_rd |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |
| flags_out | output | 8 | Current flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |

## Verification
The start request is taken at a clock edge. The first read strobe is then due in the very next cycle. For a copy, the write follows one cycle later, and the bookkeeping cycle after that updates pointers, count and flags at its closing edge. For a search, the bookkeeping cycle follows the read directly. The done pulse, together with the final outputs, is due one cycle after the last bookkeeping cycle. The bench builds the full expected cycle list for each operation from its own memory image before starting it. It compares that list against the ports at every falling edge from the first cycle after start until one cycle past done. Any extra, missing or shifted cycle therefore shows up as a mismatch.

// File: rtl/blk_xfer_pkg.sv
// Package: shared types and constants for the block copy/search sequencer.
// Assumes an 8-bit flag byte with fixed bit positions used by neighbours.
package blk_xfer_pkg;

    localparam int FW    = 8;
    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_BOOK  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic search;
        logic rpt;
        logic down;
    } op_mode_t;

    function automatic op_mode_t decode_mode(input logic [2:0] code);
        op_mode_t m;
        m.search = code[2];
        m.rpt    = code[1];
        m.down   = code[0];
        return m;
    endfunction

endpackage

// File: rtl/blk_xfer_ctrl.sv
// Sequencer control: holds the operation mode and steps through
// idle -> read -> (write) -> bookkeeping, repeating or finishing.
// Assumes stop_cond is valid during the bookkeeping cycle.
module blk_xfer_ctrl
    import blk_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] mode,
    input  logic       stop_cond,
    output seq_state_e state_q,
    output op_mode_t   mode_q,
    output logic       load,
    output logic       book,
    output logic       done
);

    seq_state_e state_d;
    logic       finish;
    logic       done_q;

    // Start is taken only while idle.
    assign load   = (state_q == ST_IDLE) && start;
    assign book   = (state_q == ST_BOOK);
    assign finish = !mode_q.rpt || stop_cond;
    assign done   = done_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = mode_q.search ? ST_BOOK : ST_WRITE;
            ST_WRITE: state_d = ST_BOOK;
            ST_BOOK:  state_d = finish ? ST_IDLE : ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, mode latch and end pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= book && finish;
            if (load) mode_q <= decode_mode(mode);
        end
    end

endmodule

// File: rtl/blk_xfer_ptrs.sv
// Pointer and count registers: two address pointers that step up or down
// and a count that steps down by one per bookkeeping cycle.
// Assumes load and book are never high together.
module blk_xfer_ptrs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          book,
    input  logic          down,
    input  logic          move_dst,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_nxt_zero
);

    localparam int NPTR = 2;

    logic [NPTR-1:0][AW-1:0] ptr_init;
    logic [NPTR-1:0]         ptr_move;
    logic [CW-1:0]           cnt_nxt;

    assign ptr_init = {dst_in, src_in};
    assign ptr_move = {move_dst, 1'b1};

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [AW-1:0] ptr_q;
        // One pointer: load at start, step by one in the chosen direction.
        always_ff @(posedge clk) begin
            if (!rst_n)                    ptr_q <= '0;
            else if (load)                 ptr_q <= ptr_init[g];
            else if (book && ptr_move[g])  ptr_q <= down ? ptr_q - AW'(1) : ptr_q + AW'(1);
        end
    end

    assign src_q = g_ptr[0].ptr_q;
    assign dst_q = g_ptr[1].ptr_q;

    assign cnt_nxt      = cnt_q - CW'(1);
    assign cnt_nxt_zero = (cnt_nxt == '0);

    // Count register: load at start, decrement once per step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= cnt_in;
        else if (book)  cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/blk_xfer_flags.sv
// Flag unit: holds the comparison byte and the flag byte, and rewrites
// the affected flags at each bookkeeping cycle.
// Assumes rdata still holds the byte of the current step's read.
module blk_xfer_flags
    import blk_xfer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          book,
    input  logic          search,
    input  logic          cnt_nxt_zero,
    input  logic [DW-1:0] acc_in,
    input  logic [FW-1:0] flags_in,
    input  logic [DW-1:0] rdata,
    output logic [FW-1:0] flags_q,
    output logic          match
);

    localparam int HALF = DW / 2;

    logic [DW-1:0] acc_q;
    logic [DW-1:0] diff;
    logic [FW-1:0] flags_d;

    assign diff  = acc_q - rdata;
    assign match = (acc_q == rdata);

    // Flag byte after one step; untouched bits pass through.
    always_comb begin
        flags_d         = flags_q;
        flags_d[FL_H]   = search && (acc_q[HALF-1:0] < rdata[HALF-1:0]);
        flags_d[FL_N]   = search;
        flags_d[FL_PV]  = !cnt_nxt_zero;
        if (search) begin
            flags_d[FL_S] = diff[DW-1];
            flags_d[FL_Z] = match;
        end
    end

    // Comparison byte and flag byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (load) begin
            acc_q   <= acc_in;
            flags_q <= flags_in;
        end else if (book) begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Top: block copy/search sequencer. Drives a synchronous memory port
// whose read data arrives one cycle after the read strobe and stays
// stable until the next read.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [DW-1:0] acc_in,
    input  logic [FW-1:0] flags_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic [FW-1:0] flags_out,
    output logic          busy,
    output logic          done
);

    seq_state_e state_q;
    op_mode_t   mode_q;
    logic       load;
    logic       book;
    logic       cnt_nxt_zero;
    logic       match;
    logic       stop_cond;

    // Copies stop on zero count; searches also stop on a match.
    assign stop_cond = cnt_nxt_zero || (mode_q.search && match);

    blk_xfer_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .stop_cond (stop_cond),
        .state_q   (state_q),
        .mode_q    (mode_q),
        .load      (load),
        .book      (book),
        .done      (done)
    );

    blk_xfer_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .book         (book),
        .down         (mode_q.down),
        .move_dst     (!mode_q.search),
        .src_in       (src_in),
        .dst_in       (dst_in),
        .cnt_in       (cnt_in),
        .src_q        (src_out),
        .dst_q        (dst_out),
        .cnt_q        (cnt_out),
        .cnt_nxt_zero (cnt_nxt_zero)
    );

    blk_xfer_flags #(.DW(DW)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .book         (book),
        .search       (mode_q.search),
        .cnt_nxt_zero (cnt_nxt_zero),
        .acc_in       (acc_in),
        .flags_in     (flags_in),
        .rdata        (mem_rdata),
        .flags_q      (flags_out),
        .match        (match)
    );

    // Memory port: read from source, write to destination.
    assign mem_rd    = (state_q == ST_READ);
    assign mem_wr    = (state_q == ST_WRITE);
    assign mem_addr  = mem_wr ? dst_out : src_out;
    assign mem_wdata = mem_rdata;
    assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/blk_xfer_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module blk_xfer_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] src_out,
    input logic [AW-1:0] dst_out,
    input logic [CW-1:0] cnt_out,
    input logic [7:0]    flags_out,
    input logic          busy,
    input logic          done
);

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    p_rd_at_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == src_out));

    p_wr_at_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == dst_out));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((cnt_out == $past(cnt_out)) || (cnt_out == $past(cnt_out) - CW'(1))));

    p_carry_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (flags_out[0] == $past(flags_out[0])));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind blk_xfer_seq blk_xfer_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .src_out   (src_out),
    .dst_out   (dst_out),
    .cnt_out   (cnt_out),
    .flags_out (flags_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/blk_xfer_seq_bench.sv
// Bench: builds the expected cycle list per operation from its own memory
// image and compares it against the ports at every falling edge.
module blk_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
    logic [7:0]  acc_i = '0, flg_i = '0;
    logic [15:0] mem_addr, src_out, dst_out, cnt_out;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, flags_out;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem     [1024];
    logic [7:0]  ref_mem [1024];

    int nchecks = 0;
    int nfails  = 0;
    int cyc     = 0;

    typedef struct {
        bit          rd;
        bit          wr;
        bit          dn;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [15:0] hl, de, bc;
        logic [7:0]  f;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    blk_xfer_seq u_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i),
        .src_in(src_i), .dst_in(dst_i), .cnt_in(cnt_i), .acc_in(acc_i),
        .flags_in(flg_i), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .flags_out(flags_out), .busy(busy), .done(done)
    );

    // Bench memory: read data one cycle after the strobe, held until next read.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            nfails = nfails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks = nchecks + 1;
        if (act !== exp) begin
            nfails = nfails + 1;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: expected cycle list for one operation.
    task automatic build(input logic [2:0] m, input logic [15:0] hl0, de0, bc0,
                         input logic [7:0] a, f0);
        logic [15:0] hl = hl0, de = de0, bc = bc0;
        logic [7:0]  f = f0, b, d;
        bit srch = m[2], rpt = m[1], dn = m[0], fin;
        exp_t e;
        forever begin
            e = '{rd:1, wr:0, dn:0, addr:hl, wd:0, hl:0, de:0, bc:0, f:0};
            q.push_back(e);
            b = ref_mem[hl[9:0]];
            if (!srch) begin
                e = '{rd:0, wr:1, dn:0, addr:de, wd:b, hl:0, de:0, bc:0, f:0};
                q.push_back(e);
                ref_mem[de[9:0]] = b;
            end
            e = '{rd:0, wr:0, dn:0, addr:0, wd:0, hl:0, de:0, bc:0, f:0};
            q.push_back(e);
            hl = dn ? hl - 16'd1 : hl + 16'd1;
            if (!srch) de = dn ? de - 16'd1 : de + 16'd1;
            bc = bc - 16'd1;
            f[2] = (bc != 0);
            if (srch) begin
                d = a - b;
                f[7] = d[7];
                f[6] = (a == b);
                f[4] = (a[3:0] < b[3:0]);
                f[1] = 1'b1;
                fin = (a == b) || (bc == 0);
            end else begin
                f[4] = 1'b0;
                f[1] = 1'b0;
                fin = (bc == 0);
            end
            if (!rpt || fin) break;
        end
        e = '{rd:0, wr:0, dn:1, addr:0, wd:0, hl:hl, de:de, bc:bc, f:f};
        q.push_back(e);
    endtask

    // Start one operation and compare every cycle until one past done.
    task automatic run_op(input logic [2:0] m, input logic [15:0] hl, de, bc,
                          input logic [7:0] a, f, input string rtag, input bit poke);
        string stag = m[2] ? "R6" : "R2";
        string ftag = m[2] ? "R9" : "R8";
        build(m, hl, de, bc, a, f);
        @(negedge clk);
        start = 1'b1; mode_i = m; src_i = hl; dst_i = de; cnt_i = bc;
        acc_i = a; flg_i = f;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            if (!q[i].dn) begin
                chk(stag, "mem_rd", 32'(mem_rd), 32'(q[i].rd));
                chk(stag, "mem_wr", 32'(mem_wr), 32'(q[i].wr));
                if (q[i].rd || q[i].wr) chk("R3", "mem_addr", 32'(mem_addr), 32'(q[i].addr));
                if (q[i].wr) chk(stag, "mem_wdata", 32'(mem_wdata), 32'(q[i].wd));
                chk(rtag, "done early", 32'(done), 32'd0);
                chk("R10", "busy", 32'(busy), 32'd1);
            end else begin
                chk(rtag, "done", 32'(done), 32'd1);
                chk("R10", "busy at done", 32'(busy), 32'd0);
                chk("R3", "src_out", 32'(src_out), 32'(q[i].hl));
                chk("R3", "dst_out", 32'(dst_out), 32'(q[i].de));
                chk("R4", "cnt_out", 32'(cnt_out), 32'(q[i].bc));
                chk(ftag, "flags_out", 32'(flags_out), 32'(q[i].f));
            end
            if (poke && i == 1) begin
                start = 1'b1; mode_i = 3'b110; src_i = 16'h0300;
                dst_i = 16'h0310; cnt_i = 16'h0007; acc_i = 8'h55; flg_i = 8'hAA;
            end
            if (poke && i == 2) start = 1'b0;
            @(negedge clk);
        end
        chk("R10", "done after pulse", 32'(done), 32'd0);
        q.delete();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 255);
            ref_mem[i] = 8'((i * 37 + 11) & 255);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mem_rd", 32'(mem_rd), 32'd0);
        chk("R1", "mem_wr", 32'(mem_wr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: single copy up, single copy down
        run_op(3'b000, 16'h0010, 16'h0100, 16'h0003, 8'h00, 8'h00, "R5", 0);
        run_op(3'b001, 16'h0020, 16'h0120, 16'h0002, 8'h00, 8'hFF, "R5", 0);
        // R5/R8: repeat copy up with all flags set, repeat copy down
        run_op(3'b010, 16'h0030, 16'h0140, 16'h0005, 8'h00, 8'hFF, "R5", 0);
        run_op(3'b011, 16'h0050, 16'h0160, 16'h0004, 8'h00, 8'h00, "R5", 0);
        // R5: overlapping repeat copy propagates the first byte
        run_op(3'b010, 16'h0200, 16'h0201, 16'h0004, 8'h00, 8'h29, "R5", 0);
        // R4: count 0000h wraps to FFFFh, P/V set
        run_op(3'b000, 16'h0060, 16'h0180, 16'h0000, 8'h00, 8'h00, "R4", 0);

        // R9: single search equal byte (Z set)
        mem[16'h0070] = 8'h42; ref_mem[16'h0070] = 8'h42;
        run_op(3'b100, 16'h0070, 16'h0000, 16'h0005, 8'h42, 8'h00, "R9", 0);
        // R9: single search, comparison below byte: S and H set, C kept
        mem[16'h0071] = 8'h25; ref_mem[16'h0071] = 8'h25;
        run_op(3'b100, 16'h0071, 16'h0000, 16'h0005, 8'h12, 8'h01, "R9", 0);
        // R7: repeat search up, match at third byte
        mem[16'h0082] = 8'hC3; ref_mem[16'h0082] = 8'hC3;
        mem[16'h0080] = 8'h00; ref_mem[16'h0080] = 8'h00;
        mem[16'h0081] = 8'h01; ref_mem[16'h0081] = 8'h01;
        run_op(3'b110, 16'h0080, 16'h0222, 16'h0008, 8'hC3, 8'h28, "R7", 0);
        // R7: repeat search down, no match, ends at zero count
        for (int i = 16'h0090; i < 16'h0095; i++) begin
            mem[i] = 8'h10; ref_mem[i] = 8'h10;
        end
        run_op(3'b111, 16'h0094, 16'h0333, 16'h0004, 8'h99, 8'h00, "R7", 0);

        // R11: start pulsed mid-operation is ignored
        run_op(3'b010, 16'h00A0, 16'h01A0, 16'h0003, 8'h00, 8'h00, "R11", 1);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

endmodule